// File: doc/BRIEF.md
# Rotating Register Window Controller

This block lets a processor core see sixteen logical registers through a movable window onto a larger physical register file. The physical file holds 64 words in 16 groups of four. A window-base pointer chooses the group that logical register 0 starts in, and the base wraps around the file. A live-group bitmap has one bit per group and marks which groups belong to active call frames.

The core issues one operation per cycle: a call-frame entry, a windowed return, a relative rotate, an absolute base set, or a stack-move liveness check. The block moves the window and updates the bitmap. For each operation it reports either success or an exception kind: illegal operation, overflow of 4, 8 or 12 registers, underflow of 4, 8 or 12 registers, or a stack-move fault. On an overflow or underflow it also reports the window base that was in force before the operation. Software handlers then spill or refill the frames. Two read ports and one write port give plain access to the logical registers through the current window.

Top module: `rwin_ctrl`

## Requirements
- R1: Logical register i reads physical word (4*base + i) mod 64. The base is 4 bits wide and wraps modulo 16. After reset the base is 0, the live bitmap is 0x0001, every physical word is zero and no result is valid.
- R2: An entry (op code 1) is illegal when the register operand is above 3, when the overflow-enable input is low, or when the exception-mode input is high. It then reports kind 1 (illegal) and leaves the base, the bitmap and the file unchanged.
- R3: An entry with call increment c checks groups base+1 .. base+c (mod 16). If any of them is live, the window moves forward to the first live one, the bitmap stays unchanged, and the old base is reported. The kind depends on the gap from that group to the next live group beyond it: a gap of 0 gives kind 2 (overflow-4), a gap of 1 gives kind 3 (overflow-8), and a larger gap gives kind 4 (overflow-12).
- R4: A legal entry with no overflow writes (logical reg s) - 8*imm into logical register 4*c + s, through the old window. It then advances the base by c, marks the new base group live, and reports kind 0.
- R5: A windowed return (op code 2) takes its frame size n from bits 31:30 of logical register 0. If the return is legal and the group at base-n is live, the base moves back by n, the old base group is cleared, kind 0 is reported, and the return PC is formed from the 2-bit region input (bits 31:30) and bits 29:0 of register 0.
- R6: A return is illegal (kind 1) when n is 0, when the nearest live group among base-1, base-2 and base-3 lies at a distance other than n, when overflow enable is low, or when exception mode is high. The base and the bitmap are then kept.
- R7: A legal return whose target group base-n is not live still moves the base back by n. It keeps the bitmap, reports the old base, and reports kind 5, 6 or 7 (underflow-4/8/12) for n = 1, 2 or 3.
- R8: A stack-move check (op code 5) reports kind 8 when none of groups base-1, base-2 and base-3 is live, and kind 0 otherwise. It changes no state.
- R9: A rotate (op code 3) adds the 4-bit argument to the base modulo 16, and a base set (op code 4) loads the argument. A read in the next cycle sees the new mapping.
- R10: Every operation other than no-op (op code 0) produces a result in the cycle after it is issued. A no-op produces no result.
- R11: The external write port writes only in a cycle whose op is no-op. The write is visible to reads in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation: 0 no-op, 1 entry, 2 return, 3 rotate, 4 set base, 5 stack-move check |
| op_sreg_i | input | 4 | Entry stack register operand s |
| op_callinc_i | input | 2 | Call increment c for entry |
| op_imm_i | input | 12 | Entry frame immediate (scaled by 8) |
| op_arg_i | input | 4 | Rotate amount or new base |
| pc_region_i | input | 2 | Top two bits of the current PC |
| ovf_en_i | input | 1 | Window overflow detection enabled |
| exc_mode_i | input | 1 | Core is in exception mode |
| rd_a_idx_i | input | 4 | Read port A logical index |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_idx_i | input | 4 | Read port B logical index |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | External write enable |
| wr_idx_i | input | 4 | External write logical index |
| wr_data_i | input | 32 | External write data |
| win_base_o | output | 4 | Current window base |
| win_live_o | output | 16 | Live-group bitmap |
| res_valid_o | output | 1 | Result of the previous cycle's operation is valid |
| res_kind_o | output | 4 | Result kind 0..8 |
| res_owb_o | output | 4 | Base recorded by the latest overflow or underflow |
| ret_pc_o | output | 32 | Target PC of the latest successful return |

## Verification
Every result, the base, the bitmap and the register contents are updated on the clock edge that ends the operation's cycle. The bench applies each operation half a period before an edge and compares kind, base, bitmap, recorded base, return PC and a read through the new window half a period after that edge. Reads are combinational from the registered base, so the read check in the same sample shows whether the mapping switched in exactly one cycle. A write that is refused is checked by reading the same logical register right after the cycle it was offered in.

// File: rtl/rwin_pkg.sv
package rwin_pkg;

    localparam int LOG_REGS   = 16;
    localparam int LOG_IDX_W  = $clog2(LOG_REGS);
    localparam int GROUP_REGS = 4;

    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_ENTRY   = 3'd1,
        OP_RETURN  = 3'd2,
        OP_ROTATE  = 3'd3,
        OP_SETBASE = 3'd4,
        OP_SPCHECK = 3'd5
    } win_op_e;

    typedef enum logic [3:0] {
        EXC_NONE    = 4'd0,
        EXC_ILLEGAL = 4'd1,
        EXC_OVF4    = 4'd2,
        EXC_OVF8    = 4'd3,
        EXC_OVF12   = 4'd4,
        EXC_UNF4    = 4'd5,
        EXC_UNF8    = 4'd6,
        EXC_UNF12   = 4'd7,
        EXC_STKMOVE = 4'd8
    } win_exc_e;

    typedef struct packed {
        logic     valid;
        win_op_e  op;
        win_exc_e kind;
    } win_res_t;

    // Overflow size from the gap to the next live group beyond the spill target
    function automatic win_exc_e ovf_kind(input logic found, input int gap);
        if (found && gap == 0)      return EXC_OVF4;
        else if (found && gap == 1) return EXC_OVF8;
        else                        return EXC_OVF12;
    endfunction

    // Underflow size from the returning frame size
    function automatic win_exc_e unf_kind(input logic [1:0] n);
        case (n)
            2'd1:    return EXC_UNF4;
            2'd2:    return EXC_UNF8;
            default: return EXC_UNF12;
        endcase
    endfunction

endpackage

// File: rtl/rwin_phys_file.sv
module rwin_phys_file #(
    parameter int NPHYS = 64,
    parameter int DW    = 32,
    parameter int NRD   = 3,
    localparam int PW   = $clog2(NPHYS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [PW-1:0]            widx,
    input  logic [DW-1:0]            wdata,
    input  logic [NRD-1:0][PW-1:0]   ridx,
    output logic [NRD-1:0][DW-1:0]   rdata
);

    logic [DW-1:0] mem [NPHYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NPHYS; i++) mem[i] <= '0;
        end else if (we) begin
            mem[widx] <= wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = mem[ridx[p]];
    end

endmodule

// File: rtl/rwin_seq.sv
module rwin_seq
    import rwin_pkg::*;
#(
    parameter int NGRP = 16,
    parameter int DW   = 32,
    parameter int IMMW = 12,
    localparam int GW  = $clog2(NGRP)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  win_op_e              op,
    input  logic [3:0]           sreg,
    input  logic [1:0]           callinc,
    input  logic [IMMW-1:0]      imm,
    input  logic [GW-1:0]        arg,
    input  logic [1:0]           pc_region,
    input  logic                 ovf_en,
    input  logic                 exc_mode,
    input  logic [DW-1:0]        aux_rdata,
    output logic [GW-1:0]        base_q,
    output logic [NGRP-1:0]      live_q,
    output win_res_t             res_q,
    output logic [GW-1:0]        owb_q,
    output logic [DW-1:0]        ret_pc_q,
    output logic                 ent_we,
    output logic [LOG_IDX_W-1:0] ent_lidx,
    output logic [DW-1:0]        ent_wdata
);

    logic [NGRP-1:0] rot;        // rot[k]: liveness of group base+1+k
    logic [2:0]      below;      // below[j-1]: liveness of group base-j
    logic            gate_bad;
    logic            ovf_hit;
    logic            found_next;
    int              first_k;
    int              gap;
    logic [1:0]      ret_n;
    logic [1:0]      near_m;

    logic [GW-1:0]   base_n;
    logic [NGRP-1:0] live_n;
    logic [GW-1:0]   owb_n;
    logic [DW-1:0]   ret_pc_n;
    win_exc_e        kind_n;

    // Circular views of the live bitmap around the base
    always_comb begin
        logic [GW-1:0] gidx;
        for (int k = 0; k < NGRP; k++) begin
            gidx   = base_q + GW'(k + 1);
            rot[k] = live_q[gidx];
        end
        for (int j = 1; j <= 3; j++) begin
            gidx       = base_q - GW'(j);
            below[j-1] = live_q[gidx];
        end
    end

    // Overflow scan: first live group within the call increment, then the gap after it
    always_comb begin
        ovf_hit = 1'b0;
        first_k = 0;
        for (int k = 0; k < 3; k++) begin
            if (k < int'(callinc) && rot[k] && !ovf_hit) begin
                ovf_hit = 1'b1;
                first_k = k;
            end
        end
        found_next = 1'b0;
        gap        = 0;
        for (int k = 0; k < NGRP; k++) begin
            if (k > first_k && rot[k] && !found_next) begin
                found_next = 1'b1;
                gap        = k - first_k - 1;
            end
        end
    end

    assign ret_n    = aux_rdata[DW-1:DW-2];
    assign near_m   = below[0] ? 2'd1 : below[1] ? 2'd2 : below[2] ? 2'd3 : 2'd0;
    assign gate_bad = !ovf_en || exc_mode;

    // Operation decision
    always_comb begin
        base_n    = base_q;
        live_n    = live_q;
        owb_n     = owb_q;
        ret_pc_n  = ret_pc_q;
        kind_n    = EXC_NONE;
        ent_we    = 1'b0;
        ent_lidx  = {callinc, sreg[1:0]};
        ent_wdata = aux_rdata - DW'({imm, 3'b000});
        case (op)
            OP_ENTRY: begin
                if (sreg > 4'd3 || gate_bad) begin
                    kind_n = EXC_ILLEGAL;
                end else if (ovf_hit) begin
                    base_n = base_q + GW'(first_k + 1);
                    owb_n  = base_q;
                    kind_n = ovf_kind(found_next, gap);
                end else begin
                    ent_we         = 1'b1;
                    base_n         = base_q + GW'(callinc);
                    live_n[base_n] = 1'b1;
                end
            end
            OP_RETURN: begin
                if (ret_n == 2'd0 || (near_m != 2'd0 && near_m != ret_n) || gate_bad) begin
                    kind_n = EXC_ILLEGAL;
                end else begin
                    ret_pc_n = {pc_region, aux_rdata[DW-3:0]};
                    base_n   = base_q - GW'(ret_n);
                    if (live_q[base_n]) begin
                        live_n[base_q] = 1'b0;
                    end else begin
                        owb_n  = base_q;
                        kind_n = unf_kind(ret_n);
                    end
                end
            end
            OP_ROTATE:  base_n = base_q + arg;
            OP_SETBASE: base_n = arg;
            OP_SPCHECK: if (below == 3'b000) kind_n = EXC_STKMOVE;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q   <= '0;
            live_q   <= NGRP'(1);
            owb_q    <= '0;
            ret_pc_q <= '0;
            res_q    <= '{valid: 1'b0, op: OP_NOP, kind: EXC_NONE};
        end else begin
            base_q      <= base_n;
            live_q      <= live_n;
            owb_q       <= owb_n;
            ret_pc_q    <= ret_pc_n;
            res_q.valid <= (op != OP_NOP);
            if (op != OP_NOP) begin
                res_q.op   <= op;
                res_q.kind <= kind_n;
            end
        end
    end

    // R2: an illegal entry reports kind 1 and moves nothing
    a_r2_illegal_entry: assert property (@(posedge clk) disable iff (rst)
        (op == OP_ENTRY && (sreg > 4'd3 || !ovf_en || exc_mode))
        |=> (res_q.kind == EXC_ILLEGAL && $stable(base_q) && $stable(live_q)));

    // R3: an overflow records the old base and keeps the bitmap
    a_r3_ovf_records_base: assert property (@(posedge clk) disable iff (rst)
        (res_q.valid && (res_q.kind == EXC_OVF4 || res_q.kind == EXC_OVF8 || res_q.kind == EXC_OVF12))
        |-> (owb_q == $past(base_q) && live_q == $past(live_q)));

    // R4: after a clean entry the new base group is live
    a_r4_entry_marks_live: assert property (@(posedge clk) disable iff (rst)
        (res_q.valid && res_q.op == OP_ENTRY && res_q.kind == EXC_NONE) |-> live_q[base_q]);

    // R5: after a clean return the frame that was left is free
    a_r5_return_frees: assert property (@(posedge clk) disable iff (rst)
        (res_q.valid && res_q.op == OP_RETURN && res_q.kind == EXC_NONE) |-> !live_q[$past(base_q)]);

    // R7: an underflow keeps the bitmap and records the old base
    a_r7_unf_keeps_live: assert property (@(posedge clk) disable iff (rst)
        (res_q.valid && (res_q.kind == EXC_UNF4 || res_q.kind == EXC_UNF8 || res_q.kind == EXC_UNF12))
        |-> (live_q == $past(live_q) && owb_q == $past(base_q)));

    // R8: the stack-move check changes no state
    a_r8_spcheck_stable: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SPCHECK) |=> ($stable(base_q) && $stable(live_q)));

    // R9: rotate steps the base by the argument in one cycle
    a_r9_rotate_step: assert property (@(posedge clk) disable iff (rst)
        (op == OP_ROTATE) |=> (base_q == GW'($past(base_q) + $past(arg))));

    // R10: a result follows every operation and only operations
    a_r10_result_follows_op: assert property (@(posedge clk) disable iff (rst)
        (op != OP_NOP) |=> res_q.valid);
    a_r10_no_result_on_nop: assert property (@(posedge clk) disable iff (rst)
        (op == OP_NOP) |=> !res_q.valid);

endmodule

// File: rtl/rwin_ctrl.sv
module rwin_ctrl
    import rwin_pkg::*;
#(
    parameter int NPHYS = 64,
    parameter int DW    = 32,
    parameter int IMMW  = 12
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [2:0]                        op_i,
    input  logic [3:0]                        op_sreg_i,
    input  logic [1:0]                        op_callinc_i,
    input  logic [IMMW-1:0]                   op_imm_i,
    input  logic [$clog2(NPHYS/4)-1:0]        op_arg_i,
    input  logic [1:0]                        pc_region_i,
    input  logic                              ovf_en_i,
    input  logic                              exc_mode_i,
    input  logic [3:0]                        rd_a_idx_i,
    output logic [DW-1:0]                     rd_a_data_o,
    input  logic [3:0]                        rd_b_idx_i,
    output logic [DW-1:0]                     rd_b_data_o,
    input  logic                              wr_en_i,
    input  logic [3:0]                        wr_idx_i,
    input  logic [DW-1:0]                     wr_data_i,
    output logic [$clog2(NPHYS/4)-1:0]        win_base_o,
    output logic [NPHYS/4-1:0]                win_live_o,
    output logic                              res_valid_o,
    output logic [3:0]                        res_kind_o,
    output logic [$clog2(NPHYS/4)-1:0]        res_owb_o,
    output logic [DW-1:0]                     ret_pc_o
);

    localparam int NGRP = NPHYS / GROUP_REGS;
    localparam int GW   = $clog2(NGRP);
    localparam int PW   = $clog2(NPHYS);
    localparam int NRD  = 3;

    win_op_e                op;
    logic [GW-1:0]          base_q;
    logic [NGRP-1:0]        live_q;
    win_res_t               res_q;
    logic                   ent_we;
    logic [LOG_IDX_W-1:0]   ent_lidx;
    logic [DW-1:0]          ent_wdata;
    logic [LOG_IDX_W-1:0]   aux_lidx;
    logic                   pf_we;
    logic [PW-1:0]          pf_widx;
    logic [DW-1:0]          pf_wdata;
    logic [NRD-1:0][PW-1:0] pf_ridx;
    logic [NRD-1:0][DW-1:0] pf_rdata;

    function automatic logic [PW-1:0] to_phys(input logic [GW-1:0] b,
                                              input logic [LOG_IDX_W-1:0] l);
        return {b, 2'b00} + PW'(l);
    endfunction

    assign op = win_op_e'(op_i);

    // Entry reads its stack register, return reads register 0
    assign aux_lidx = (op == OP_RETURN) ? '0 : {2'b00, op_sreg_i[1:0]};

    assign pf_ridx[0] = to_phys(base_q, rd_a_idx_i);
    assign pf_ridx[1] = to_phys(base_q, rd_b_idx_i);
    assign pf_ridx[2] = to_phys(base_q, aux_lidx);

    // Entry write wins; the port write is accepted only on idle cycles
    assign pf_we    = ent_we || (wr_en_i && op == OP_NOP);
    assign pf_widx  = ent_we ? to_phys(base_q, ent_lidx) : to_phys(base_q, wr_idx_i);
    assign pf_wdata = ent_we ? ent_wdata : wr_data_i;

    rwin_phys_file #(
        .NPHYS (NPHYS),
        .DW    (DW),
        .NRD   (NRD)
    ) u_file (
        .clk   (clk),
        .rst   (rst),
        .we    (pf_we),
        .widx  (pf_widx),
        .wdata (pf_wdata),
        .ridx  (pf_ridx),
        .rdata (pf_rdata)
    );

    rwin_seq #(
        .NGRP (NGRP),
        .DW   (DW),
        .IMMW (IMMW)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .sreg      (op_sreg_i),
        .callinc   (op_callinc_i),
        .imm       (op_imm_i),
        .arg       (op_arg_i),
        .pc_region (pc_region_i),
        .ovf_en    (ovf_en_i),
        .exc_mode  (exc_mode_i),
        .aux_rdata (pf_rdata[2]),
        .base_q    (base_q),
        .live_q    (live_q),
        .res_q     (res_q),
        .owb_q     (res_owb_o),
        .ret_pc_q  (ret_pc_o),
        .ent_we    (ent_we),
        .ent_lidx  (ent_lidx),
        .ent_wdata (ent_wdata)
    );

    assign rd_a_data_o = pf_rdata[0];
    assign rd_b_data_o = pf_rdata[1];
    assign win_base_o  = base_q;
    assign win_live_o  = live_q;
    assign res_valid_o = res_q.valid;
    assign res_kind_o  = res_q.kind;

    // R11: a port write offered during an operation leaves the target word alone
    a_r11_port_write_blocked: assert property (@(posedge clk) disable iff (rst)
        (op != OP_NOP && op != OP_ENTRY && wr_en_i)
        |=> (u_file.mem[$past(to_phys(base_q, wr_idx_i))] == $past(u_file.mem[to_phys(base_q, wr_idx_i)])));

endmodule

// File: tb/test_rwin_ctrl.sv
module test_rwin_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  op_i;
    logic [3:0]  op_sreg_i;
    logic [1:0]  op_callinc_i;
    logic [11:0] op_imm_i;
    logic [3:0]  op_arg_i;
    logic [1:0]  pc_region_i;
    logic        ovf_en_i;
    logic        exc_mode_i;
    logic [3:0]  rd_a_idx_i;
    logic [31:0] rd_a_data_o;
    logic [3:0]  rd_b_idx_i;
    logic [31:0] rd_b_data_o;
    logic        wr_en_i;
    logic [3:0]  wr_idx_i;
    logic [31:0] wr_data_i;
    logic [3:0]  win_base_o;
    logic [15:0] win_live_o;
    logic        res_valid_o;
    logic [3:0]  res_kind_o;
    logic [3:0]  res_owb_o;
    logic [31:0] ret_pc_o;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    rwin_ctrl i_rwin_ctrl (
        .clk (clk), .rst (rst),
        .op_i (op_i), .op_sreg_i (op_sreg_i), .op_callinc_i (op_callinc_i),
        .op_imm_i (op_imm_i), .op_arg_i (op_arg_i), .pc_region_i (pc_region_i),
        .ovf_en_i (ovf_en_i), .exc_mode_i (exc_mode_i),
        .rd_a_idx_i (rd_a_idx_i), .rd_a_data_o (rd_a_data_o),
        .rd_b_idx_i (rd_b_idx_i), .rd_b_data_o (rd_b_data_o),
        .wr_en_i (wr_en_i), .wr_idx_i (wr_idx_i), .wr_data_i (wr_data_i),
        .win_base_o (win_base_o), .win_live_o (win_live_o),
        .res_valid_o (res_valid_o), .res_kind_o (res_kind_o),
        .res_owb_o (res_owb_o), .ret_pc_o (ret_pc_o)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic [3:0]  s;
        logic [1:0]  ci;
        logic [11:0] imm;
        logic [3:0]  arg;
        logic [1:0]  region;
        logic        woe;
        logic        excm;
        logic        we;
        logic [31:0] wd;
        logic        rchk;
        logic [3:0]  ridx;
        logic [31:0] rexp;
        logic [3:0]  kind;
        logic [3:0]  base;
        logic [15:0] live;
        logic [3:0]  owb;
        logic [31:0] rpc;
    } vec_t;

    localparam int NVEC = 31;
    // op s ci imm arg region woe excm we wd rchk ridx rexp kind base live owb rpc
    localparam vec_t VECS [NVEC] = '{
        '{3'd1, 4'd1, 2'd1, 12'd2, 4'd0,  2'd0, 1'b1, 1'b0, 1'b0, 32'h0,         1'b1, 4'd1,  32'h0000_00F1, 4'd0, 4'd1,  16'h0003, 4'd0,  32'h0},
        '{3'd1, 4'd1, 2'd2, 12'd1, 4'd0,  2'd0, 1'b1, 1'b0, 1'b0, 32'h0,         1'b1, 4'd1,  32'h0000_00E9, 4'd0, 4'd3,  16'h000B, 4'd0,  32'h0},
        '{3'd1, 4'd5, 2'd1, 12'd0, 4'd0,  2'd0, 1'b1, 1'b0, 1'b0, 32'h0,         1'b0, 4'd0,  32'h0,         4'd1, 4'd3,  16'h000B, 4'd0,  32'h0},
        '{3'd1, 4'd0, 2'd1, 12'd0, 4'd0,  2'd0, 1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 4'd0,  32'h0,         4'd1, 4'd3,  16'h000B, 4'd0,  32'h0},
        '{3'd1, 4'd0, 2'd1, 12'd0, 4'd0,  2'd0, 1'b1, 1'b1, 1'b0, 32'h0,         1'b0, 4'd0,  32'h0,         4'd1, 4'd3,  16'h000B, 4'd0,  32'h0},
        '{3'd5, 4'd0, 2'd0, 12'd0, 4'd0,  2'd0, 1'b1, 1'b0, 1'b0, 32'h0,         1'b0, 4'd0,  32'h0,         4'd0, 4'd3,  16'h000B, 4'd0,  32'h0},
        '{3'd2, 4'd0, 2'd0, 12'd0, 4'd0,  2'd3, 1'b1, 1'b1, 1'b0, 32'h0,         1'b0, 4'd0,  32'h0,         4'd1, 4'd3,  16'h000B, 4'd0,  32'h0},
        '{3'd2, 4'd0, 2'd0, 12'd0, 4'd0,  2'd3, 1'b1, 1'b0, 1'b0, 32'h0,         1'b1, 4'd1,  32'h0000_00F1, 4'd0, 4'd1,  16'h0003, 4'd0,  32'hC000_1234},
        '{3'd1, 4'd0, 2'd1, 12'd0, 4'd0,  2'd0, 1'b1, 1'b0, 1'b0, 32'h0,         1'b1, 4'd0,  32'h0000_0104, 4'd0, 4'd2,  16'h0007, 4'd0,  32'h0},
        '{3'd4, 4'd0, 2'd0, 12'd0, 4'd0,  2'd0, 1'b1, 1'b0, 1'b0, 32'h0,         1'b1, 4'd12, 32'h8000_1234, 4'd0, 4'd0,  16'h0007, 4'd0,  32'h0},
        '{3'd1, 4'd0, 2'd1, 12'd0, 4'd0,  2'd0, 1'b1, 1'b0, 1'b0, 32'h0,         1'b0, 4'd0,  32'h0,         4'd2, 4'd1,  16'h0007, 4'd0,  32'h0},
        '{3'd0, 4'd0, 2'd0, 12'd0, 4'd0,  2'd0, 1'b1, 1'b0, 1'b1, 32'h4000_0010, 1'b1, 4'd0,  32'h4000_0010, 4'd0, 4'd1,  16'h0007, 4'd0,  32'h0},
        '{3'd2, 4'd0, 2'd0, 12'd0, 4'd0,  2'd2, 1'b1, 1'b0, 1'b0, 32'h0,         1'b0, 4'd0,  32'h0,         4'd0, 4'd0,  16'h0005, 4'd0,  32'h8000_0010},
        '{3'd1, 4'd0, 2'd2, 12'd0, 4'd0,  2'd0, 1'b1, 1'b0, 1'b0, 32'h0,         1'b0, 4'd0,  32'h0,         4'd4, 4'd2,  16'h0005, 4'd0,  32'h0},
        '{3'd4, 4'd0, 2'd0, 12'd0, 4'd15, 2'd0, 1'b1, 1'b0, 1'b0, 32'h0,         1'b1, 4'd4,  32'h0000_0100, 4'd0, 4'd15, 16'h0005, 4'd0,  32'h0},
        '{3'd1, 4'd0, 2'd1, 12'd0, 4'd0,  2'd0, 1'b1, 1'b0, 1'b0, 32'h0,         1'b0, 4'd0,  32'h0,         4'd3, 4'd0,  16'h0005, 4'd15, 32'h0},
        '{3'd3, 4'd0, 2'd0, 12'd0, 4'd14, 2'd0, 1'b1, 1'b0, 1'b1, 32'hDEAD_BEEF, 1'b1, 4'd0,  32'h0,         4'd0, 4'd14, 16'h0005, 4'd0,  32'h0},
        '{3'd5, 4'd0, 2'd0, 12'd0, 4'd0,  2'd0, 1'b1, 1'b0, 1'b0, 32'h0,         1'b0, 4'd0,  32'h0,         4'd8, 4'd14, 16'h0005, 4'd0,  32'h0},
        '{3'd0, 4'd0, 2'd0, 12'd0, 4'd0,  2'd0, 1'b1, 1'b0, 1'b1, 32'h8000_0000, 1'b0, 4'd0,  32'h0,         4'd0, 4'd14, 16'h0005, 4'd0,  32'h0},
        '{3'd2, 4'd0, 2'd0, 12'd0, 4'd0,  2'd0, 1'b1, 1'b0, 1'b0, 32'h0,         1'b0, 4'd0,  32'h0,         4'd6, 4'd12, 16'h0005, 4'd14, 32'h0},
        '{3'd2, 4'd0, 2'd0, 12'd0, 4'd0,  2'd0, 1'b1, 1'b0, 1'b0, 32'h0,         1'b0, 4'd0,  32'h0,         4'd1, 4'd12, 16'h0005, 4'd0,  32'h0},
        '{3'd4, 4'd0, 2'd0, 12'd0, 4'd2,  2'd0, 1'b1, 1'b0, 1'b0, 32'h0,         1'b0, 4'd0,  32'h0,         4'd0, 4'd2,  16'h0005, 4'd0,  32'h0},
        '{3'd0, 4'd0, 2'd0, 12'd0, 4'd0,  2'd0, 1'b1, 1'b0, 1'b1, 32'h4000_0000, 1'b0, 4'd0,  32'h0,         4'd0, 4'd2,  16'h0005, 4'd0,  32'h0},
        '{3'd2, 4'd0, 2'd0, 12'd0, 4'd0,  2'd0, 1'b1, 1'b0, 1'b0, 32'h0,         1'b0, 4'd0,  32'h0,         4'd1, 4'd2,  16'h0005, 4'd0,  32'h0},
        '{3'd0, 4'd0, 2'd0, 12'd0, 4'd0,  2'd0, 1'b1, 1'b0, 1'b1, 32'h8000_0020, 1'b0, 4'd0,  32'h0,         4'd0, 4'd2,  16'h0005, 4'd0,  32'h0},
        '{3'd2, 4'd0, 2'd0, 12'd0, 4'd0,  2'd1, 1'b1, 1'b0, 1'b0, 32'h0,         1'b0, 4'd0,  32'h0,         4'd0, 4'd0,  16'h0001, 4'd0,  32'h4000_0020},
        '{3'd0, 4'd0, 2'd0, 12'd0, 4'd0,  2'd0, 1'b1, 1'b0, 1'b1, 32'hC000_0000, 1'b0, 4'd0,  32'h0,         4'd0, 4'd0,  16'h0001, 4'd0,  32'h0},
        '{3'd2, 4'd0, 2'd0, 12'd0, 4'd0,  2'd0, 1'b1, 1'b0, 1'b0, 32'h0,         1'b0, 4'd0,  32'h0,         4'd7, 4'd13, 16'h0001, 4'd0,  32'h0},
        '{3'd4, 4'd0, 2'd0, 12'd0, 4'd5,  2'd0, 1'b1, 1'b0, 1'b0, 32'h0,         1'b0, 4'd0,  32'h0,         4'd0, 4'd5,  16'h0001, 4'd0,  32'h0},
        '{3'd0, 4'd0, 2'd0, 12'd0, 4'd0,  2'd0, 1'b1, 1'b0, 1'b1, 32'h4000_0000, 1'b0, 4'd0,  32'h0,         4'd0, 4'd5,  16'h0001, 4'd0,  32'h0},
        '{3'd2, 4'd0, 2'd0, 12'd0, 4'd0,  2'd0, 1'b1, 1'b0, 1'b0, 32'h0,         1'b0, 4'd0,  32'h0,         4'd5, 4'd4,  16'h0001, 4'd5,  32'h0}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input vec_t v);
        case (v.kind)
            4'd1:              return (v.op == 3'd1) ? "R2" : "R6";
            4'd2, 4'd3, 4'd4:  return "R3";
            4'd5, 4'd6, 4'd7:  return "R7";
            4'd8:              return "R8";
            default: case (v.op)
                3'd1:       return "R4";
                3'd2:       return "R5";
                3'd3, 3'd4: return "R9";
                3'd5:       return "R8";
                default:    return "R11";
            endcase
        endcase
    endfunction

    task automatic idle();
        op_i = 3'd0; op_sreg_i = '0; op_callinc_i = '0; op_imm_i = '0;
        op_arg_i = '0; pc_region_i = '0; ovf_en_i = 1'b1; exc_mode_i = 1'b0;
        wr_en_i = 1'b0; wr_idx_i = '0; wr_data_i = '0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        idle();
        rd_a_idx_i = '0;
        rd_b_idx_i = '0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R12-style reset view, tagged under R1 (mapping and reset state)
        check("R1", "reset base", 32'(win_base_o), 32'd0);
        check("R1", "reset live", 32'(win_live_o), 32'h0001);
        check("R10", "reset valid", 32'(res_valid_o), 32'd0);
        check("R1", "reset reg", rd_a_data_o, 32'h0);

        // Fill the first window through the port (R11 accepted on no-op cycles)
        for (int i = 0; i < 16; i++) begin
            wr_en_i   = 1'b1;
            wr_idx_i  = 4'(i);
            wr_data_i = (i == 12) ? 32'h8000_1234 : 32'h100 + 32'(i);
            @(posedge clk);
            @(negedge clk);
        end
        wr_en_i = 1'b0;
        rd_a_idx_i = 4'd5;
        rd_b_idx_i = 4'd12;
        #1;
        check("R11", "port write a", rd_a_data_o, 32'h105);
        check("R1", "read b base0", rd_b_data_o, 32'h8000_1234);
        check("R10", "no result from writes", 32'(res_valid_o), 32'd0);

        // Table walk
        for (int n = 0; n < NVEC; n++) begin
            vec_t v;
            v = VECS[n];
            op_i = v.op; op_sreg_i = v.s; op_callinc_i = v.ci; op_imm_i = v.imm;
            op_arg_i = v.arg; pc_region_i = v.region; ovf_en_i = v.woe;
            exc_mode_i = v.excm; wr_en_i = v.we; wr_idx_i = 4'd0; wr_data_i = v.wd;
            rd_a_idx_i = v.ridx;
            @(posedge clk);
            @(negedge clk);
            check("R10", $sformatf("row %0d valid", n), 32'(res_valid_o), 32'(v.op != 3'd0));
            if (v.op != 3'd0)
                check(req_of(v), $sformatf("row %0d kind", n), 32'(res_kind_o), 32'(v.kind));
            check(req_of(v), $sformatf("row %0d base", n), 32'(win_base_o), 32'(v.base));
            check(req_of(v), $sformatf("row %0d live", n), 32'(win_live_o), 32'(v.live));
            if (v.kind >= 4'd2 && v.kind <= 4'd7)
                check(req_of(v), $sformatf("row %0d owb", n), 32'(res_owb_o), 32'(v.owb));
            if (v.op == 3'd2 && v.kind == 4'd0)
                check("R5", $sformatf("row %0d ret pc", n), ret_pc_o, v.rpc);
            if (v.rchk)
                check((v.op == 3'd3) ? "R11" : "R9", $sformatf("row %0d read", n), rd_a_data_o, v.rexp);
        end
        idle();

        // Port B through the final window (base 4): logical 0 is physical 16, still zero
        rd_b_idx_i = 4'd0;
        #1;
        check("R1", "read b base4", rd_b_data_o, 32'h0);

        // Reset in the middle of use
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        rd_a_idx_i = 4'd0;
        #1;
        check("R1", "re-reset base", 32'(win_base_o), 32'd0);
        check("R1", "re-reset live", 32'(win_live_o), 32'h0001);
        check("R1", "re-reset reg", rd_a_data_o, 32'h0);
        check("R10", "re-reset valid", 32'(res_valid_o), 32'd0);

        finish_run();
    end

endmodule